// File: doc/BRIEF.md
# Local-History Two-Level Branch Predictor

This block predicts the direction of conditional branches from each branch's own recent behaviour. A table of eight per-branch history registers, selected by low word-address bits of the program counter, records the last three outcomes of whichever branches map to each slot. That three-bit history then selects one entry of a single shared table of eight two-bit saturating counters, and the counter's upper bit gives the taken/not-taken guess.

Fetch logic presents a program counter on the predict side and reads the guess back in the same cycle. When a branch resolves, the pipeline presents its program counter and real direction on the update side. On the following clock edge the chosen history register takes in the outcome, and the counter that the old history pointed at steps toward that outcome. Each counter is a four-state machine. Its states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). The INC transition on a taken update moves it one state toward STRONG_T and holds at STRONG_T. The DEC transition on a not-taken update moves it one state toward STRONG_NT and holds at STRONG_NT. The HOLD transition, taken whenever the counter is not the one being updated, leaves it unchanged.

Top module: `lhist_predictor`

## Requirements
- R1: The history slot is chosen by program-counter bits [4:2]. Addresses that differ only outside those bits share a slot, and addresses that differ in those bits use separate slots.
- R2: Each slot holds three outcome bits, with 1 meaning taken. An update shifts the slot left by one, drops the oldest bit and places the new outcome in bit 0.
- R3: There is one shared table of eight counters, and the three-bit history value is used directly as the counter number, both when predicting and when updating.
- R4: A counter encodes 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. A taken update increments it and stops at 11. A not-taken update decrements it and stops at 00. The guess is taken exactly when bit 1 of the selected counter is 1.
- R5: A counter that is in 11 still predicts taken after one not-taken update, and predicts not-taken only after a second not-taken update.
- R6: After reset every history slot is 000 and every counter is 01, so every address predicts not-taken.
- R7: The guess is combinational from the predict address and stored state. An update changes state only at the next rising clock edge, so a guess made in the cycle of an update reflects the state before that update. With the update-valid input low, no state changes, whatever the other update inputs carry.
- R8: A single branch whose outcomes repeat N,T,T,T is predicted without error once it has been trained: history TTT predicts N, and histories NTT, TNT and TTN predict T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | Program counter of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | 32 | Program counter of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
On every cycle, the assertions check the shift of the updated history slot, the saturating step of the counter that the old history selected, that nothing moves without a valid update, that the guess matches the upper bit of the counter selected by the current history, and the state right after reset. The bench's scenarios are needed to show behaviour that spans many updates: the two-miss hysteresis of a saturated counter, sharing between aliased addresses, and error-free prediction of the repeating N,T,T,T stream once training has finished. It checks every guess against a reference model built from the requirements, under a long random mix of addresses and outcomes.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    // Two-bit saturating direction counter; the encoding is part of the contract.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WEAK_NT;

endpackage

// File: rtl/lhp_ctr_fsm.sv
module lhp_ctr_fsm
    import lhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       taken,
    output logic       pred_o,
    output ctr_state_e state_o
);

    ctr_state_e state_q;
    ctr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: INC on taken, DEC on not-taken, HOLD when not stepped
    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                CTR_STRONG_NT: state_d = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   state_d = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    state_d = taken ? CTR_STRONG_T : CTR_WEAK_NT;
                CTR_STRONG_T:  state_d = taken ? CTR_STRONG_T : CTR_WEAK_T;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CTR_STRONG_NT: pred_o = 1'b0;
            CTR_WEAK_NT:   pred_o = 1'b0;
            CTR_WEAK_T:    pred_o = 1'b1;
            CTR_STRONG_T:  pred_o = 1'b1;
        endcase
        state_o = state_q;
    end

endmodule

// File: rtl/lhp_history_table.sv
module lhp_history_table #(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [HIST_W-1:0]           rd_hist,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_taken,
    output logic [HIST_W-1:0]           wr_hist,
    output logic [(HIST_W<<IDX_W)-1:0]  hist_vec
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [ENTRIES];
    logic [HIST_W:0]   shifted;

    assign rd_hist = hist_q[rd_idx];
    assign wr_hist = hist_q[wr_idx];
    assign shifted = {wr_hist, wr_taken};

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q[g] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    hist_q[g] <= shifted[HIST_W-1:0];
                end
            end
            assign hist_vec[g*HIST_W +: HIST_W] = hist_q[g];
        end
    endgenerate

endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HIST_W-1:0]          rd_hist,
    output logic                       rd_taken,
    input  logic                       wr_en,
    input  logic [HIST_W-1:0]          wr_hist,
    input  logic                       wr_taken,
    output logic [(2<<HIST_W)-1:0]     state_vec
);

    localparam int COUNTERS = 1 << HIST_W;

    logic [COUNTERS-1:0] pred_bits;

    genvar g;
    generate
        for (g = 0; g < COUNTERS; g++) begin : g_ctr
            ctr_state_e st;
            lhp_ctr_fsm u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .step    (wr_en && wr_hist == HIST_W'(g)),
                .taken   (wr_taken),
                .pred_o  (pred_bits[g]),
                .state_o (st)
            );
            assign state_vec[2*g +: 2] = st;
        end
    endgenerate

    assign rd_taken = pred_bits[rd_hist];

endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor #(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 3,
    parameter int HIST_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int HVEC_W = HIST_W << IDX_W;
    localparam int CVEC_W = 2 << HIST_W;

    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [HIST_W-1:0] pred_hist;
    logic [HIST_W-1:0] upd_hist;
    logic [HVEC_W-1:0] hist_vec;
    logic [CVEC_W-1:0] pht_vec;

    // Low word-address bits pick the slot, so neighbouring branches spread out.
    assign pred_idx = pred_pc[IDX_LSB +: IDX_W];
    assign upd_idx  = upd_pc[IDX_LSB +: IDX_W];

    wire pc_unused_bits = ^{pred_pc, upd_pc};

    lhp_history_table #(
        .IDX_W  (IDX_W),
        .HIST_W (HIST_W)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_hist  (pred_hist),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .wr_hist  (upd_hist),
        .hist_vec (hist_vec)
    );

    lhp_pattern_table #(
        .HIST_W (HIST_W)
    ) u_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hist   (pred_hist),
        .rd_taken  (pred_taken),
        .wr_en     (upd_valid),
        .wr_hist   (upd_hist),
        .wr_taken  (upd_taken),
        .state_vec (pht_vec)
    );

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        upd_valid,
    input logic                        upd_taken,
    input logic                        pred_taken,
    input logic [IDX_W-1:0]            pred_idx,
    input logic [IDX_W-1:0]            upd_idx,
    input logic [HIST_W-1:0]           upd_hist,
    input logic [(HIST_W<<IDX_W)-1:0]  hist_vec,
    input logic [(2<<HIST_W)-1:0]      pht_vec
);

    localparam int SLOTS    = 1 << IDX_W;
    localparam int COUNTERS = 1 << HIST_W;

    function automatic logic [1:0] sat_step(input logic [1:0] s, input logic t);
        if (t) return (s == 2'b11) ? s : s + 2'd1;
        return (s == 2'b00) ? s : s - 2'd1;
    endfunction

    function automatic logic [HIST_W-1:0] slot_of(input logic [(HIST_W<<IDX_W)-1:0] v,
                                                  input logic [IDX_W-1:0] i);
        return v[HIST_W*int'(i) +: HIST_W];
    endfunction

    function automatic logic [1:0] ctr_of(input logic [(2<<HIST_W)-1:0] v,
                                          input logic [HIST_W-1:0] h);
        return v[2*int'(h) +: 2];
    endfunction

    // R2: the updated slot takes in the outcome at bit 0
    p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> slot_of(hist_vec, $past(upd_idx)) ==
                      {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)});

    // R3 R4: the counter addressed by the old history steps with saturation
    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ctr_of(pht_vec, $past(upd_hist)) ==
                      sat_step($past(ctr_of(pht_vec, upd_hist)), $past(upd_taken)));

    // R7: without a valid update nothing moves
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_vec) && $stable(pht_vec));

    // R3 R4: guess follows the upper bit of the counter picked by the current history
    p_guess_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == ctr_of(pht_vec, slot_of(hist_vec, pred_idx))[1]);

    // R6: state immediately after reset release
    p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hist_vec == '0) && (pht_vec == {COUNTERS{2'b01}}));

    wire slots_unused = (SLOTS == 0);

endmodule

bind lhist_predictor lhp_checker #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_taken),
    .pred_idx   (pred_idx),
    .upd_idx    (upd_idx),
    .upd_hist   (upd_hist),
    .hist_vec   (hist_vec),
    .pht_vec    (pht_vec)
);

// File: tb/lhist_predictor_bench.sv
`timescale 1ns/1ps
module lhist_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    lhist_predictor u_lhist_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    // Reference model from the requirements
    logic [2:0] m_hist [8];
    logic [1:0] m_ctr  [8];

    function automatic logic m_pred(input logic [31:0] pc);
        return m_ctr[m_hist[pc[4:2]]][1];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 8; i++) begin
            m_hist[i] = 3'b000;
            m_ctr[i]  = 2'b01;
        end
    endtask

    task automatic m_update(input logic [31:0] pc, input logic t);
        logic [2:0] h;
        h = m_hist[pc[4:2]];
        if (t) m_ctr[h] = (m_ctr[h] == 2'b11) ? 2'b11 : m_ctr[h] + 2'd1;
        else   m_ctr[h] = (m_ctr[h] == 2'b00) ? 2'b00 : m_ctr[h] - 2'd1;
        m_hist[pc[4:2]] = {h[1:0], t};
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check the combinational guess, then let the edge pass.
    task automatic cyc(input logic [31:0] ppc, input logic v, input logic [31:0] upc,
                       input logic t, input string req, output logic guess);
        @(negedge clk);
        pred_pc   = ppc;
        upd_valid = v;
        upd_pc    = upc;
        upd_taken = t;
        #1;
        guess = pred_taken;
        check(pred_taken, m_pred(ppc), req);
        @(posedge clk);
        if (v) m_update(upc, t);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic g;
        logic [31:0] r;
        int errs;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: every slot predicts not-taken after reset
        for (int i = 0; i < 8; i++) begin
            cyc(32'(i * 4), 1'b0, 32'h0, 1'b1, "R6", g);
            check(g, 1'b0, "R6 reset guess");
        end

        // R5: saturate counter 7 via all-taken history, then two single misses
        for (int i = 0; i < 8; i++) cyc(32'h14, 1'b1, 32'h14, 1'b1, "R4", g);
        cyc(32'h14, 1'b1, 32'h14, 1'b0, "R5", g);
        check(g, 1'b1, "R5 saturated guess");
        for (int i = 0; i < 3; i++) cyc(32'h14, 1'b1, 32'h14, 1'b1, "R2", g);
        cyc(32'h14, 1'b0, 32'h0, 1'b0, "R5", g);
        check(g, 1'b1, "R5 after one miss");
        cyc(32'h14, 1'b1, 32'h14, 1'b0, "R5", g);
        for (int i = 0; i < 3; i++) cyc(32'h14, 1'b1, 32'h14, 1'b1, "R2", g);
        cyc(32'h14, 1'b0, 32'h0, 1'b0, "R5", g);
        check(g, 1'b0, "R5 after two misses");

        // R7: idle cycles with junk on the update side leave the guess alone
        for (int i = 0; i < 8; i++) cyc(32'h14, 1'b0, 32'h14, i[0], "R7 idle", g);

        // R8: repeating N,T,T,T on one branch
        for (int p = 0; p < 16; p++) begin
            cyc(32'h40, 1'b1, 32'h40, 1'b0, "R2 R8", g);
            for (int k = 0; k < 3; k++) cyc(32'h40, 1'b1, 32'h40, 1'b1, "R2 R8", g);
        end
        errs = 0;
        for (int p = 0; p < 20; p++) begin
            cyc(32'h40, 1'b1, 32'h40, 1'b0, "R8", g);
            check(g, 1'b0, "R8 trained N");
            for (int k = 0; k < 3; k++) begin
                cyc(32'h40, 1'b1, 32'h40, 1'b1, "R8", g);
                check(g, 1'b1, "R8 trained T");
            end
        end

        // R1: aliases of slot 0 above bit 4 and in bits 1:0 share its history
        cyc(32'hFFFF_FFE3, 1'b0, 32'h0, 1'b0, "R1 alias", g);
        cyc(32'h0000_0060, 1'b0, 32'h0, 1'b0, "R1 alias", g);
        cyc(32'h0000_0044, 1'b0, 32'h0, 1'b0, "R1 separate slot", g);

        // R1 R3 R4 R7: random mix, same-cycle predict and update of one branch included
        for (int n = 0; n < 2000; n++) begin
            r = $urandom;
            if (n % 7 == 0) cyc(r, r[31], r, r[30], "R7 same-cycle", g);
            else            cyc({$urandom}, (r[1:0] != 2'b00), {r[31:5], r[4:2], r[1:0]},
                                r[9], "R1 R3 R4 random", g);
        end

        // R6: reset mid-run restores the initial state
        @(negedge clk);
        rst_n = 1'b0;
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(32'(i * 4 + 32'h100), 1'b0, 32'h0, 1'b0, "R6 re-reset", g);
            check(g, 1'b0, "R6 re-reset guess");
        end

        if (errs != 0) failures++;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule